// File: doc/BRIEF.md
# Host-Loaded Shared Register Memory

A byte-wide storage array with two sides. A host processor loads it through a port that is synchronous to `clk`. User logic reads it through an address-to-data path that has no clock and no handshake.

The host has two ways to load the array. It can fill the whole array in order, starting from location 0 and moving up one byte per write strobe. It can also update one byte at an address it supplies. A `busy` output tells the reader that the contents may be changing. During a fill, `busy` stays high from the start pulse until the last location has been written.

Reads are never locked against host writes. A reader that samples while `busy` is high may see a mix of old and new bytes. Such a reader should wait for `busy` to drop before it trusts a multi-byte view.

Top module: `shared_byte_store`

## Requirements
- R1: `rd_data` equals the byte stored at `rd_addr` and follows a change of `rd_addr` with no clock edge in between.
- R2: A one-cycle pulse on `host_block_start` begins a fill. `busy` is high in the pulse cycle and stays high after it. A `host_wr` in the pulse cycle is discarded.
- R3: During a fill, each `host_wr` stores `host_data` at the next location in ascending order, starting from 0. `host_addr` and `host_single` are ignored while a fill is running.
- R4: After the clock edge that writes location 2**ADDR_W-1 of a fill, `busy` is low and the fill is over. A later `host_wr` with `host_single` low changes nothing.
- R5: When no fill is running, `host_wr` with `host_single` high stores `host_data` at `host_addr`. Every other location is left unchanged.
- R6: For a single-byte write, `busy` is high in the cycle the write is accepted and low in the cycle after it.
- R7: A `host_block_start` that arrives during a fill restarts it at location 0, and `busy` stays high.
- R8: A synchronous active-high `rst` ends any fill and drives `busy` low. The stored bytes are kept.
- R9: When no fill is running, `host_wr` with `host_single` low has no effect.
- R10: A read during a fill returns the bytes already written by that fill, together with the older bytes at the locations the fill has not reached yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the host side |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle write strobe |
| host_addr | input | ADDR_W | Target address for a single-byte write |
| host_data | input | DATA_W | Byte to be written |
| host_block_start | input | 1 | Pulse that begins or restarts a fill |
| host_single | input | 1 | Selects a single-byte write at `host_addr` |
| rd_addr | input | ADDR_W | User read address |
| rd_data | output | DATA_W | Byte stored at `rd_addr`, combinational |
| busy | output | 1 | High while the contents may be changing |

## Verification
Each result has a fixed cycle in which it is due:
- A stored byte appears on `rd_data` once the write edge has passed. No further latency is added, because the read path is purely combinational.
- During the stimulus cycle itself, `busy` already reflects a start pulse or an accepted single write.
- The fill-end drop of `busy` is visible right after the edge that writes the last location.

The bench drives inputs at the falling edge. It checks `busy` one time step later, while the stimulus is still applied. It checks the array contents after the following falling edge. Each read address is stepped with a short delay and no clock edge, so the read checks also exercise the combinational path.

// File: rtl/shared_byte_store.sv
module shared_byte_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              host_block_start,
  input  logic              host_single,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              blk_on;
  logic [ADDR_W-1:0] blk_ptr;

  wire blk_wr = blk_on & host_wr & ~host_block_start;
  wire sgl_wr = ~blk_on & host_wr & host_single & ~host_block_start;
  wire [ADDR_W-1:0] wr_addr = blk_on ? blk_ptr : host_addr;

  always_ff @(posedge clk)
    if (blk_wr | sgl_wr) mem[wr_addr] <= host_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_on  <= 1'b0;
      blk_ptr <= '0;
    end else if (host_block_start) begin
      blk_on  <= 1'b1;
      blk_ptr <= '0;
    end else if (blk_wr) begin
      blk_ptr <= blk_ptr + 1'b1;
      if (blk_ptr == LAST) blk_on <= 1'b0;
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = blk_on | host_block_start | sgl_wr;

  AST_START_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    host_block_start |=> busy && blk_ptr == '0);                       // R2
  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (rst)
    (blk_wr && blk_ptr != LAST) |=> blk_on && blk_ptr == $past(blk_ptr) + 1'b1); // R3
  AST_FILL_ENDS: assert property (@(posedge clk) disable iff (rst)
    (blk_wr && blk_ptr == LAST) |=> !blk_on);                          // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (blk_on && host_block_start) |=> blk_on && blk_ptr == '0);         // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data))); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !blk_on);                                                  // R8
endmodule

// File: tb/tb_shared_byte_store.sv
module tb_shared_byte_store;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_data = '0;
  logic          host_block_start = 1'b0;
  logic          host_single = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy;

  logic [7:0] exp_mem [N];
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  shared_byte_store #(.ADDR_W(AW), .DATA_W(8)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_data(host_data), .host_block_start(host_block_start),
    .host_single(host_single), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    for (int a = 0; a < N; a++) begin
      rd_addr = AW'(a);
      #1;
      chk(rd_data === exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
    end
  endtask

  task automatic check_busy(input bit e, input string req);
    chk(busy === e, req, int'(busy), int'(e));
  endtask

  // Apply one stimulus cycle, check busy while it is applied, then idle.
  task automatic cyc(input bit wr, input int addr, input int data, input bit start,
                     input bit single, input bit busy_exp, input string req);
    @(negedge clk);
    host_wr = wr; host_addr = AW'(addr); host_data = 8'(data);
    host_block_start = start; host_single = single;
    #1 check_busy(busy_exp, req);
    @(negedge clk);
    host_wr = 0; host_block_start = 0; host_single = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check_busy(0, "R8 reset busy");
    rst = 0;

    // R5/R6: single writes to every address
    for (int a = 0; a < N; a++) begin
      exp_mem[a] = 8'(a * 37 + 5);
      cyc(1, a, a * 37 + 5, 0, 1, 1, "R6 busy in accept cycle");
      #1 check_busy(0, "R6 busy low after");
    end
    check_mem("R5 single write / R1 read");

    // R9: write strobe without single select while idle
    cyc(1, 2, 8'hFF, 0, 0, 0, "R9 no busy");
    check_mem("R9 ignored write");

    // R2: start pulse with a concurrent write that must be discarded
    cyc(1, 0, 8'hEE, 1, 0, 1, "R2 busy in start cycle");
    #1 check_busy(1, "R2 busy after start");
    check_mem("R2 write in start cycle discarded");

    // R3/R10: partial fill, host_addr and host_single ignored
    for (int i = 0; i < 3; i++) begin
      exp_mem[i] = 8'(8'h80 + i);
      cyc(1, 7, 8'h80 + i, 0, 1, 1, "R3 busy mid fill");
    end
    check_mem("R10 partial fill visible / R3 order");
    check_busy(1, "R3 busy still high");

    // R7: restart, then complete fill
    cyc(0, 0, 0, 1, 0, 1, "R7 busy on restart");
    #1 check_busy(1, "R7 busy kept");
    for (int i = 0; i < N; i++) begin
      exp_mem[i] = 8'(8'h40 + i);
      cyc(1, 3, 8'h40 + i, 0, 0, 1, "R7 busy during refill");
    end
    #1 check_busy(0, "R4 busy low after last location");
    check_mem("R7 refill from zero / R3");

    // R4: after fill end, plain strobe is ignored
    cyc(1, 0, 8'h11, 0, 0, 0, "R4 no busy after fill");
    check_mem("R4 strobe after fill ignored");

    // R3: single select during fill goes to the fill pointer
    cyc(0, 0, 0, 1, 0, 1, "R2 start again");
    exp_mem[0] = 8'h5A;
    cyc(1, 5, 8'h5A, 0, 1, 1, "R3 busy");
    check_mem("R3 host_addr ignored during fill");

    // R8: reset mid fill ends it, contents kept
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    #1 check_busy(0, "R8 busy cleared by reset");
    cyc(1, 1, 8'h33, 0, 0, 0, "R8 no fill after reset");
    check_mem("R8 contents retained");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule